// File: doc/BRIEF.md
# GPIO Edge/Level Interrupt Unit

This block watches 32 general-purpose input pins and turns activity on them into one combined interrupt request for a host processor. Each pin passes through a synchroniser. It is then judged either by its level, with a selectable active polarity, or by its edges. The rising and falling edges can each be inhibited. An edge event can be held in a sticky status bit until software clears it, or passed through as a one-cycle pulse.

The pins form two 16-bit halves, and every register has a low-half word and a high-half word. Software reaches status, enable, type, polarity, hold and the two edge-inhibit masks through a 16-bit word-write/combinational-read port. Status bits are cleared by writing a one to them.

Besides the combined request, the block reports the number of the pin the host should service. This is the lowest-numbered pending, enabled pin in the low half. Only when the low half has nothing pending is it the lowest such pin in the high half.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every configuration register and every status bit reads zero, `irq_out` is 0 and `src_valid` is 0.
- R2: The register word index is `2*kind + half` (half 0 covers pins 0-15, half 1 covers pins 16-31). The kinds are 0 status, 1 enable, 2 type, 3 polarity, 4 hold, 5 fall-inhibit and 6 rise-inhibit. Indices 14 and 15 read zero. Words of kinds 1 to 6 read back the value last written.
- R3: A pin whose type bit is 0 is level-detected. Its status bit equals the synchronised input when its polarity bit is 1, and the inverted input when it is 0. The status changes on the third rising clock edge after the pin changes.
- R4: A pin with type bit 1 and hold bit 1 sets its status bit on a detected edge, three clock edges after the pin changes. The bit stays set until a 1 is written to it. Writing 0 to it has no effect.
- R5: A pin with type bit 1 and hold bit 0 shows a detected edge as a status pulse exactly one clock cycle long, with no latching.
- R6: A set rise-inhibit bit suppresses rising-edge detection on its pin, and a set fall-inhibit bit suppresses falling-edge detection. With both bits clear, both edges are detected.
- R7: When an edge event and a write-one-to-clear reach the same held status bit on the same clock edge, the bit remains set.
- R8: `irq_out` is 1 exactly when some pin has both its status bit and its enable bit set.
- R9: When `src_valid` is 1, `src_id` is the lowest-numbered pending, enabled pin of pins 0-15. If none of those is pending, it is the lowest-numbered pending, enabled pin of pins 16-31.
- R10: When no pin is pending and enabled, `src_valid` is 0 and `src_id` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 32 | Asynchronous pin inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index (2*kind + half) |
| reg_wdata | input | 16 | Write data; for status, ones clear bits |
| reg_rdata | output | 16 | Combinational read data of the addressed word |
| irq_out | output | 1 | Combined interrupt request |
| src_valid | output | 1 | A pending, enabled pin exists |
| src_id | output | 5 | Number of the pin to service |

## Verification
Every one of the 32 pins is swept through a held rising and falling edge. This exposes a design that mis-slices the halves, for example by reporting pin 16 as pin 0, or one that loses a bit after a write of zero. Mixed pending patterns under several enable masks are drained one source at a time. A priority encoder that ranked the high half first, or counted disabled pins, would report the wrong pin in the middle of the drain. A clear timed onto the same edge as a new event catches a design that lets the clear win and drops an interrupt. Level sampling one cycle early, a pass-through pulse that lingers, and edge inhibits wired to the wrong direction each show up as a status value wrong in one specific cycle.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
   // Register kinds; word index on the bus is 2*kind + half.
   typedef enum logic [2:0] {
      K_STAT = 3'd0,
      K_EN   = 3'd1,
      K_TYPE = 3'd2,
      K_POL  = 3'd3,
      K_HOLD = 3'd4,
      K_FINH = 3'd5,
      K_RINH = 3'd6
   } reg_kind_e;

   typedef struct packed {
      logic edge_mode;
      logic pol_high;
      logic hold;
      logic fall_inh;
      logic rise_inh;
   } pin_cfg_t;
endpackage

// File: rtl/gpio_irq_sync.sv
`timescale 1ns/1ps
module gpio_irq_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_irq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int k = 1; k < STAGES; k++) begin
            chain[k] <= chain[k-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_irq_cell.sv
`timescale 1ns/1ps
module gpio_irq_cell
   import gpio_irq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     sync_in,
   input  pin_cfg_t cfg,
   input  logic     clr,
   output logic     status
);
   logic prev_q;
   logic st_q;
   logic st_d;
   logic rise_ev;
   logic fall_ev;
   logic edge_ev;
   logic lvl_act;

   assign rise_ev = sync_in & ~prev_q & ~cfg.rise_inh;
   assign fall_ev = ~sync_in & prev_q & ~cfg.fall_inh;
   assign edge_ev = rise_ev | fall_ev;
   assign lvl_act = cfg.pol_high ? sync_in : ~sync_in;

   always_comb begin
      if (!cfg.edge_mode) begin
         st_d = lvl_act;
      end else if (cfg.hold) begin
         // a fresh event outranks a clear on the same edge
         st_d = (st_q & ~clr) | edge_ev;
      end else begin
         st_d = edge_ev;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         st_q   <= 1'b0;
      end else begin
         prev_q <= sync_in;
         st_q   <= st_d;
      end
   end

   assign status = st_q;
endmodule

// File: rtl/gpio_irq_prio.sv
`timescale 1ns/1ps
module gpio_irq_prio #(
   parameter int HALF_W = 16,
   localparam int NPIN   = 2 * HALF_W,
   localparam int HIDX_W = $clog2(HALF_W),
   localparam int IDX_W  = HIDX_W + 1
) (
   input  logic [NPIN-1:0]  pend,
   output logic             valid,
   output logic [IDX_W-1:0] id
);
   logic [1:0]              any_h;
   logic [1:0][HIDX_W-1:0]  idx_h;

   for (genvar h = 0; h < 2; h++) begin : g_half
      always_comb begin
         any_h[h] = |pend[h*HALF_W +: HALF_W];
         idx_h[h] = '0;
         for (int b = HALF_W - 1; b >= 0; b--) begin
            if (pend[h*HALF_W + b]) idx_h[h] = HIDX_W'(b);
         end
      end
   end

   always_comb begin
      valid = |any_h;
      if (any_h[0])      id = {1'b0, idx_h[0]};
      else if (any_h[1]) id = {1'b1, idx_h[1]};
      else               id = '0;
   end
endmodule

// File: rtl/gpio_irq_unit.sv
`timescale 1ns/1ps
module gpio_irq_unit
   import gpio_irq_pkg::*;
#(
   parameter int HALF_W      = 16,
   parameter int SYNC_STAGES = 2,
   localparam int NPIN   = 2 * HALF_W,
   localparam int IDX_W  = $clog2(NPIN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPIN-1:0]   pin_in,
   input  logic              reg_we,
   input  logic [3:0]        reg_addr,
   input  logic [HALF_W-1:0] reg_wdata,
   output logic [HALF_W-1:0] reg_rdata,
   output logic              irq_out,
   output logic              src_valid,
   output logic [IDX_W-1:0]  src_id
);
   if (HALF_W < 2 || (HALF_W & (HALF_W - 1)) != 0) begin : g_bad_half
      $error("gpio_irq_unit: HALF_W must be a power of two >= 2");
   end

   reg_kind_e        kind;
   int               hbase;
   logic [NPIN-1:0]  sync_v;
   logic [NPIN-1:0]  st_vec;
   logic [NPIN-1:0]  pend_vec;
   logic [NPIN-1:0]  clr_v;
   logic [NPIN-1:0]  en_q, type_q, pol_q, hold_q, finh_q, rinh_q;
   logic [NPIN-1:0]  sel_vec;

   assign kind  = reg_kind_e'(reg_addr[3:1]);
   assign hbase = reg_addr[0] ? HALF_W : 0;

   gpio_irq_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (sync_v)
   );

   // configuration write path
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         type_q <= '0;
         pol_q  <= '0;
         hold_q <= '0;
         finh_q <= '0;
         rinh_q <= '0;
      end else if (reg_we) begin
         case (kind)
            K_EN:    en_q  [hbase +: HALF_W] <= reg_wdata;
            K_TYPE:  type_q[hbase +: HALF_W] <= reg_wdata;
            K_POL:   pol_q [hbase +: HALF_W] <= reg_wdata;
            K_HOLD:  hold_q[hbase +: HALF_W] <= reg_wdata;
            K_FINH:  finh_q[hbase +: HALF_W] <= reg_wdata;
            K_RINH:  rinh_q[hbase +: HALF_W] <= reg_wdata;
            default: ;
         endcase
      end
   end

   // write-one-to-clear mask for status
   always_comb begin
      clr_v = '0;
      if (reg_we && kind == K_STAT) clr_v[hbase +: HALF_W] = reg_wdata;
   end

   for (genvar p = 0; p < NPIN; p++) begin : g_pin
      pin_cfg_t cfg;
      assign cfg = '{edge_mode: type_q[p], pol_high: pol_q[p], hold: hold_q[p],
                     fall_inh: finh_q[p], rise_inh: rinh_q[p]};
      gpio_irq_cell u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .sync_in (sync_v[p]),
         .cfg     (cfg),
         .clr     (clr_v[p]),
         .status  (st_vec[p])
      );
   end

   assign pend_vec = st_vec & en_q;
   assign irq_out  = |pend_vec;

   gpio_irq_prio #(.HALF_W(HALF_W)) u_prio (
      .pend  (pend_vec),
      .valid (src_valid),
      .id    (src_id)
   );

   // combinational read path
   always_comb begin
      case (kind)
         K_STAT:  sel_vec = st_vec;
         K_EN:    sel_vec = en_q;
         K_TYPE:  sel_vec = type_q;
         K_POL:   sel_vec = pol_q;
         K_HOLD:  sel_vec = hold_q;
         K_FINH:  sel_vec = finh_q;
         K_RINH:  sel_vec = rinh_q;
         default: sel_vec = '0;
      endcase
      reg_rdata = sel_vec[hbase +: HALF_W];
   end
endmodule

// File: rtl/gpio_irq_chk.sv
`timescale 1ns/1ps
module gpio_irq_chk #(
   parameter int HALF_W = 16,
   localparam int NPIN  = 2 * HALF_W,
   localparam int IDX_W = $clog2(NPIN)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq_out,
   input logic             src_valid,
   input logic [IDX_W-1:0] src_id,
   input logic [NPIN-1:0]  pend,
   input logic [NPIN-1:0]  st,
   input logic [NPIN-1:0]  ty,
   input logic [NPIN-1:0]  ho,
   input logic [NPIN-1:0]  clr
);
   logic [NPIN-1:0] below;
   logic [NPIN-1:0] keep;
   logic [NPIN-1:0] one_v;

   assign one_v = NPIN'(1);
   assign below = (one_v << src_id) - one_v;
   assign keep  = st & ty & ho & ~clr;

   // R8 / R10: encoder valid and combined request agree
   a_r10_valid_matches_irq: assert property (@(posedge clk) disable iff (!rst_n)
      src_valid == irq_out);

   // R9: reported pin is itself pending
   a_r9_source_pending: assert property (@(posedge clk) disable iff (!rst_n)
      src_valid |-> pend[src_id]);

   // R9: no lower-numbered pin is pending
   a_r9_none_below: assert property (@(posedge clk) disable iff (!rst_n)
      src_valid |-> ((pend & below) == '0));

   // R10: idle source number is zero
   a_r10_idle_id: assert property (@(posedge clk) disable iff (!rst_n)
      !src_valid |-> (src_id == '0));

   // R4: a held edge status bit not being cleared stays set
   a_r4_hold_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(keep) & ~st) == '0));
endmodule

bind gpio_irq_unit gpio_irq_chk #(.HALF_W(HALF_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_out   (irq_out),
   .src_valid (src_valid),
   .src_id    (src_id),
   .pend      (pend_vec),
   .st        (st_vec),
   .ty        (type_q),
   .ho        (hold_q),
   .clr       (clr_v)
);

// File: tb/sim_gpio_irq_unit.sv
`timescale 1ns/1ps
module sim_gpio_irq_unit;
   localparam int HW = 16;
   localparam int NP = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pins = '0;
   logic          we = 1'b0;
   logic [3:0]    addr = '0;
   logic [HW-1:0] wdata = '0;
   logic [HW-1:0] rdata;
   logic          irq;
   logic          sv;
   logic [4:0]    sid;
   int            n_vec = 0;
   int            n_bad = 0;

   always #2.5 clk = ~clk;

   gpio_irq_unit #(.HALF_W(HW)) u0 (
      .clk(clk), .rst_n(rst_n), .pin_in(pins), .reg_we(we), .reg_addr(addr),
      .reg_wdata(wdata), .reg_rdata(rdata), .irq_out(irq), .src_valid(sv), .src_id(sid)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      addr = a; wdata = d; we = 1'b1;
      @(posedge clk);
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      addr = a;
      #0.1;
      d = rdata;
   endtask

   task automatic rd_status(output logic [31:0] v);
      logic [15:0] lo, hi;
      rd(4'd0, lo);
      rd(4'd1, hi);
      v = {hi, lo};
   endtask

   task automatic set_both(input int kind, input logic [31:0] v);
      wr(4'(2*kind), v[15:0]);
      wr(4'(2*kind + 1), v[31:16]);
   endtask

   task automatic clr_pin(input int i);
      wr(4'(i / 16), 16'(1 << (i % 16)));
   endtask

   function automatic int lowest(input logic [31:0] v);
      for (int i = 0; i < 32; i++) if (v[i]) return i;
      return 0;
   endfunction

   initial begin
      #(100000 * 5.0);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] d;
      logic [31:0] s;
      logic [31:0] pats [5];
      logic [31:0] ppat [5];
      logic [31:0] emsk [3];

      // ---------------- R1 reset state
      step(3);
      rd_status(s);
      check("R1 status in reset", s, 32'h0);
      rst_n = 1'b1;
      check("R1 irq after reset", {31'b0, irq}, 32'h0);
      check("R1 valid after reset", {31'b0, sv}, 32'h0);
      for (int a = 2; a < 14; a++) begin
         rd(4'(a), d);
         check("R1 config reads zero", {16'h0, d}, 32'h0);
         step(1);
      end

      // ---------------- R2 readback of config words
      for (int a = 2; a < 14; a++) wr(4'(a), 16'(16'h1234 * (a + 1)) ^ 16'h5A5A);
      for (int a = 2; a < 16; a++) begin
         rd(4'(a), d);
         if (a < 14) check("R2 readback", {16'h0, d}, {16'h0, 16'(16'h1234 * (a + 1)) ^ 16'h5A5A});
         else        check("R2 unmapped reads zero", {16'h0, d}, 32'h0);
         step(1);
      end
      for (int a = 2; a < 14; a++) wr(4'(a), 16'h0);

      // ---------------- R3 level detection, polarity high on low half, low on high half
      set_both(3, 32'h0000_FFFF);
      step(4);
      pats = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h1357_9BDF, 32'hA5A5_0F0F, 32'h8001_4002};
      for (int k = 0; k < 5; k++) begin
         pins = pats[k];
         step(2);
         if (k > 0) begin
            rd_status(s);
            check("R3 level not yet updated", s, {~pats[k-1][31:16], pats[k-1][15:0]});
         end
         step(1);
         rd_status(s);
         check("R3 level status", s, {~pats[k][31:16], pats[k][15:0]});
      end

      // ---------------- R4/R6/R8/R9 held edges on every pin
      pins = '0;
      step(4);
      set_both(2, 32'hFFFF_FFFF);
      set_both(4, 32'hFFFF_FFFF);
      set_both(1, 32'hFFFF_FFFF);
      wr(4'd0, 16'hFFFF);
      wr(4'd1, 16'hFFFF);
      rd_status(s);
      check("R4 status cleared", s, 32'h0);
      for (int i = 0; i < NP; i++) begin
         pins[i] = 1'b1;
         step(3);
         rd_status(s);
         check("R4 rising edge latched", s, 32'(1) << i);
         check("R9 source id", {27'h0, sid}, 32'(i));
         check("R8 irq raised", {31'b0, irq}, 32'h1);
         wr(4'(i / 16), 16'h0);
         step(5);
         rd_status(s);
         check("R4 zero write and time leave bit", s, 32'(1) << i);
         clr_pin(i);
         rd_status(s);
         check("R4 write one clears", s, 32'h0);
         check("R10 idle valid", {31'b0, sv}, 32'h0);
         check("R10 idle id", {27'h0, sid}, 32'h0);
         pins[i] = 1'b0;
         step(3);
         rd_status(s);
         check("R6 falling edge detected", s, 32'(1) << i);
         clr_pin(i);
      end

      // ---------------- R9/R8/R10 priority drain, falling edges inhibited
      set_both(5, 32'hFFFF_FFFF);
      ppat = '{32'h8001_0010, 32'hF0F0_0000, 32'h0000_8000, 32'h0003_C00C, 32'hFFFF_FFFF};
      emsk = '{32'hFFFF_FFFF, 32'hFF00_00FF, 32'h00FF_0000};
      for (int k = 0; k < 5; k++) begin
         for (int m = 0; m < 3; m++) begin
            logic [31:0] pend;
            set_both(1, emsk[m]);
            pins = ppat[k];
            step(3);
            pend = ppat[k] & emsk[m];
            check("R8 irq vs pending", {31'b0, irq}, {31'b0, |pend});
            while (pend != 0) begin
               int lo;
               lo = lowest(pend);
               check("R9 drain valid", {31'b0, sv}, 32'h1);
               check("R9 drain order", {27'h0, sid}, 32'(lo));
               clr_pin(lo);
               pend[lo] = 1'b0;
            end
            check("R10 drained valid", {31'b0, sv}, 32'h0);
            check("R10 drained id", {27'h0, sid}, 32'h0);
            wr(4'd0, 16'hFFFF);
            wr(4'd1, 16'hFFFF);
            pins = '0;
            step(3);
            rd_status(s);
            check("R6 falling inhibited", s, 32'h0);
         end
      end
      set_both(1, 32'hFFFF_FFFF);

      // ---------------- R6 rise inhibit, both inhibits
      set_both(5, 32'h0);
      set_both(6, 32'hFFFF_FFFF);
      pins[5] = 1'b1;
      step(3);
      rd_status(s);
      check("R6 rising inhibited", s, 32'h0);
      pins[5] = 1'b0;
      step(3);
      rd_status(s);
      check("R6 falling still seen", s, 32'h20);
      clr_pin(5);
      set_both(5, 32'hFFFF_FFFF);
      pins[20] = 1'b1;
      step(3);
      rd_status(s);
      check("R6 both inhibited rise", s, 32'h0);
      pins[20] = 1'b0;
      step(3);
      rd_status(s);
      check("R6 both inhibited fall", s, 32'h0);
      set_both(5, 32'h0);
      set_both(6, 32'h0);

      // ---------------- R5 pass-through pulses
      set_both(4, 32'h0);
      pins[9] = 1'b1;
      step(3);
      rd_status(s);
      check("R5 pulse present", s, 32'h200);
      check("R5 pulse irq id", {27'h0, sid}, 32'd9);
      step(1);
      rd_status(s);
      check("R5 pulse gone", s, 32'h0);
      check("R5 irq dropped", {31'b0, irq}, 32'h0);
      pins[9] = 1'b0;
      step(3);
      check("R5 falling pulse", {31'b0, irq}, 32'h1);
      step(1);
      check("R5 falling pulse gone", {31'b0, irq}, 32'h0);

      // ---------------- R7 event beats clear on the same edge
      set_both(4, 32'hFFFF_FFFF);
      pins[18] = 1'b1;
      step(3);
      rd_status(s);
      check("R7 setup latched", s, 32'h4_0000);
      pins[18] = 1'b0;
      step(2);
      clr_pin(18);
      rd_status(s);
      check("R7 event wins over clear", s, 32'h4_0000);
      clr_pin(18);
      rd_status(s);
      check("R7 later clear works", s, 32'h0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule